// File: doc/BRIEF.md
# Inter-Core Interrupt Request Unit

This block lets any core of a cluster raise an interrupt on any other core, itself included. Every core owns one port on a small 32-bit register bus. A core signals another by writing a single shared trigger word. That word carries two IDs: the core that sends and the core that receives.

For each receiving core the block keeps a pending-sender bitmap. The interrupt line of that core stays high while any bit of its bitmap is set. The interrupt controller sees this line as internal interrupt 16. The receiver reads its bitmap to learn who asked for attention. It then drops the requests it has served by writing ones to those bit positions.

All ports act in the same clock cycle with no arbitration. If several cores trigger at once, every request is kept.

Top module: `ici_unit`

## Requirements
- R1: After reset every pending-sender bitmap reads zero, every interrupt line is low and every port's read data is zero.
- R2: A write to byte offset 0x3FFC with the sender ID in data bits [19:16] and the receiver ID in data bits [3:0] sets bit [sender] of the receiver's bitmap from the next cycle on. A core may signal itself.
- R3: A read at byte offset 4*n, for n below CORE_CNT, returns receiver n's bitmap in data bits [CORE_CNT-1:0] with all higher bits zero. The data appears on that port the cycle after the request. It holds the bitmap as it stood before any update in that same cycle.
- R4: A write at byte offset 4*n clears each bitmap bit of receiver n whose data bit is 1. Bits written as 0 are left unchanged.
- R5: Interrupt line n is high exactly when receiver n's bitmap is non-zero.
- R6: Triggers issued on several ports in the same cycle are all recorded. This holds whether they target different bits or the same bit.
- R7: If a trigger sets a bit and a write-one clears that same bit in the same cycle, the bit ends up set. Other bits named in the same clear are still cleared.
- R8: A trigger whose sender or receiver ID is CORE_CNT or above changes no bitmap.
- R9: A write to any offset other than the trigger word or an in-range bitmap changes nothing. A read from any such offset returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised inside the block |
| bus_req | input | CORE_CNT | Per-port access request |
| bus_we | input | CORE_CNT | Per-port write enable (1 = write, 0 = read) |
| bus_addr | input | CORE_CNT*16 | Per-port byte offset, port p in bits [16p+15:16p] |
| bus_wdata | input | CORE_CNT*32 | Per-port write data, port p in bits [32p+31:32p] |
| bus_rdata | output | CORE_CNT*32 | Per-port registered read data, port p in bits [32p+31:32p] |
| ici_irq | output | CORE_CNT | Per-core inter-core interrupt line |

## Verification
Each write is captured at one rising edge. Its effect on the bitmaps and on the interrupt lines is therefore due right after that edge. Read data is due after the edge that follows the request cycle, and it reflects the bitmap from before that edge. The bench drives each request on a falling edge and removes it on the next falling edge. It samples interrupt lines and read data on that second falling edge, and checks them against a model updated under the same set-wins rule. In the read-during-write case the bench expects the old bitmap on the read port and the new one on the next read.

// File: rtl/ici_pkg.sv
package ici_pkg;
  localparam int ADDR_W   = 16;
  localparam int DATA_W   = 32;
  localparam int ID_W     = 4;
  localparam int SND_LSB  = 16;
  localparam logic [ADDR_W-1:0] TRIG_OFS = 16'h3FFC;
endpackage

// File: rtl/ici_rst_sync.sv
module ici_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_sync_n = out_q;
endmodule

// File: rtl/ici_port_decode.sv
module ici_port_decode
  import ici_pkg::*;
#(
  parameter int CORE_CNT = 4
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              req,
  input  logic                              we,
  input  logic [ADDR_W-1:0]                 addr,
  input  logic [DATA_W-1:0]                 wdata,
  output logic [CORE_CNT-1:0][CORE_CNT-1:0] set_map,
  output logic [CORE_CNT-1:0][CORE_CNT-1:0] clr_map,
  output logic                              rd_en,
  output logic                              rd_hit,
  output logic [ID_W-1:0]                   rd_idx
);
  localparam logic [ID_W:0] CNT_L = CORE_CNT[ID_W:0];

  logic [ID_W-1:0] snd_id;
  logic [ID_W-1:0] rcv_id;
  logic [ID_W-1:0] stat_idx;
  logic            is_trig;
  logic            trig_ok;
  logic            stat_hit;
  logic            stat_wr;
  logic            unused_bits;

  assign snd_id   = wdata[SND_LSB +: ID_W];
  assign rcv_id   = wdata[ID_W-1:0];
  assign stat_idx = addr[ID_W+1:2];

  assign is_trig  = req && we && (addr == TRIG_OFS);
  assign trig_ok  = is_trig && ({1'b0, snd_id} < CNT_L) && ({1'b0, rcv_id} < CNT_L);
  assign stat_hit = (addr[1:0] == 2'b00) && (addr[ADDR_W-1:ID_W+2] == '0)
                    && ({1'b0, stat_idx} < CNT_L);
  assign stat_wr  = req && we && stat_hit;

  assign rd_en  = req && !we;
  assign rd_hit = stat_hit;
  assign rd_idx = stat_idx;

  for (genvar r = 0; r < CORE_CNT; r++) begin : g_rcv
    for (genvar s = 0; s < CORE_CNT; s++) begin : g_snd
      assign set_map[r][s] = trig_ok && (rcv_id == ID_W'(r)) && (snd_id == ID_W'(s));
    end
    assign clr_map[r] = (stat_wr && (stat_idx == ID_W'(r))) ? wdata[CORE_CNT-1:0] : '0;
  end

  assign unused_bits = ^wdata;

  // A trigger naming an absent core must request no set
  assert_range_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (is_trig && (({1'b0, snd_id} >= CNT_L) || ({1'b0, rcv_id} >= CNT_L))) |-> (set_map == '0));

  // A write outside the mapped offsets must neither set nor clear
  assert_unmapped_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req && we && (addr != TRIG_OFS) && !stat_hit) |-> ((set_map == '0) && (clr_map == '0)));
endmodule

// File: rtl/ici_status_bank.sv
module ici_status_bank #(
  parameter int CORE_CNT = 4
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [CORE_CNT-1:0][CORE_CNT-1:0] set_any,
  input  logic [CORE_CNT-1:0][CORE_CNT-1:0] clr_any,
  output logic [CORE_CNT-1:0][CORE_CNT-1:0] stat_q,
  output logic [CORE_CNT-1:0]               irq
);
  for (genvar r = 0; r < CORE_CNT; r++) begin : g_rcv
    logic [CORE_CNT-1:0] stat_d;
    logic                stat_en;

    always_comb begin
      stat_en = (|set_any[r]) || (|clr_any[r]);
      stat_d  = (stat_q[r] & ~clr_any[r]) | set_any[r];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stat_q[r] <= '0;
      end else if (stat_en) begin
        stat_q[r] <= stat_d;
      end
    end

    assign irq[r] = |stat_q[r];

    for (genvar s = 0; s < CORE_CNT; s++) begin : g_bit
      // A set request always lands, even against a clear
      assert_set_lands_R7: assert property (@(posedge clk) disable iff (!rst_n)
        set_any[r][s] |=> stat_q[r][s]);
      // A clear without a competing set empties the bit
      assert_clear_works_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_any[r][s] && !set_any[r][s]) |=> !stat_q[r][s]);
    end

    // With no request the bitmap holds
    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ((set_any[r] == '0) && (clr_any[r] == '0)) |=> $stable(stat_q[r]));
  end
endmodule

// File: rtl/ici_read_port.sv
module ici_read_port
  import ici_pkg::*;
#(
  parameter int CORE_CNT = 4
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              rd_en,
  input  logic                              rd_hit,
  input  logic [ID_W-1:0]                   rd_idx,
  input  logic [CORE_CNT-1:0][CORE_CNT-1:0] stat_q,
  output logic [DATA_W-1:0]                 rdata
);
  logic [CORE_CNT-1:0] sel_stat;
  logic [DATA_W-1:0]   rdata_d;
  logic [DATA_W-1:0]   rdata_q;

  always_comb begin
    sel_stat = '0;
    for (int k = 0; k < CORE_CNT; k++) begin
      if (rd_idx == ID_W'(k)) sel_stat = stat_q[k];
    end
    rdata_d = rd_hit ? DATA_W'(sel_stat) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rd_en) begin
      rdata_q <= rdata_d;
    end
  end

  assign rdata = rdata_q;

  // Unmapped read returns zero
  assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !rd_hit) |=> (rdata == '0));
  // Read data never carries bits above the core count
  assert_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd_en) |-> (rdata[DATA_W-1:CORE_CNT] == '0));
endmodule

// File: rtl/ici_unit.sv
module ici_unit
  import ici_pkg::*;
#(
  parameter int CORE_CNT = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [CORE_CNT-1:0]          bus_req,
  input  logic [CORE_CNT-1:0]          bus_we,
  input  logic [CORE_CNT*ADDR_W-1:0]   bus_addr,
  input  logic [CORE_CNT*DATA_W-1:0]   bus_wdata,
  output logic [CORE_CNT*DATA_W-1:0]   bus_rdata,
  output logic [CORE_CNT-1:0]          ici_irq
);
  logic rst_sync_n;

  logic [CORE_CNT-1:0][CORE_CNT-1:0] set_map [CORE_CNT];
  logic [CORE_CNT-1:0][CORE_CNT-1:0] clr_map [CORE_CNT];
  logic [CORE_CNT-1:0]               rd_en;
  logic [CORE_CNT-1:0]               rd_hit;
  logic [ID_W-1:0]                   rd_idx [CORE_CNT];
  logic [CORE_CNT-1:0][CORE_CNT-1:0] set_any;
  logic [CORE_CNT-1:0][CORE_CNT-1:0] clr_any;
  logic [CORE_CNT-1:0][CORE_CNT-1:0] stat_q;

  ici_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  for (genvar p = 0; p < CORE_CNT; p++) begin : g_port
    ici_port_decode #(.CORE_CNT(CORE_CNT)) u_dec (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .req     (bus_req[p]),
      .we      (bus_we[p]),
      .addr    (bus_addr[p*ADDR_W +: ADDR_W]),
      .wdata   (bus_wdata[p*DATA_W +: DATA_W]),
      .set_map (set_map[p]),
      .clr_map (clr_map[p]),
      .rd_en   (rd_en[p]),
      .rd_hit  (rd_hit[p]),
      .rd_idx  (rd_idx[p])
    );

    ici_read_port #(.CORE_CNT(CORE_CNT)) u_rd (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .rd_en  (rd_en[p]),
      .rd_hit (rd_hit[p]),
      .rd_idx (rd_idx[p]),
      .stat_q (stat_q),
      .rdata  (bus_rdata[p*DATA_W +: DATA_W])
    );
  end

  always_comb begin
    set_any = '0;
    clr_any = '0;
    for (int p = 0; p < CORE_CNT; p++) begin
      set_any = set_any | set_map[p];
      clr_any = clr_any | clr_map[p];
    end
  end

  ici_status_bank #(.CORE_CNT(CORE_CNT)) u_bank (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .set_any (set_any),
    .clr_any (clr_any),
    .stat_q  (stat_q),
    .irq     (ici_irq)
  );

  for (genvar r = 0; r < CORE_CNT; r++) begin : g_chk
    // An interrupt line only rises after a trigger for that receiver
    assert_irq_cause_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
      $rose(ici_irq[r]) |-> $past(|set_any[r]));
    // A line falls only when a clear was aimed at it
    assert_irq_drop_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
      $fell(ici_irq[r]) |-> $past(|clr_any[r]));
  end
endmodule

// File: tb/ici_unit_tb.sv
`timescale 1ns/1ps
module ici_unit_tb;
  localparam int N = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0]    bus_req;
  logic [N-1:0]    bus_we;
  logic [N*16-1:0] bus_addr;
  logic [N*32-1:0] bus_wdata;
  logic [N*32-1:0] bus_rdata;
  logic [N-1:0]    ici_irq;

  logic        t_req [N];
  logic        t_we  [N];
  logic [15:0] t_adr [N];
  logic [31:0] t_dat [N];
  logic [N-1:0] exp_map [N];

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  always_comb begin
    for (int p = 0; p < N; p++) begin
      bus_req[p] = t_req[p];
      bus_we[p]  = t_we[p];
      bus_addr[p*16 +: 16] = t_adr[p];
      bus_wdata[p*32 +: 32] = t_dat[p];
    end
  end

  ici_unit #(.CORE_CNT(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ici_irq(ici_irq)
  );

  task automatic idle_all();
    for (int p = 0; p < N; p++) begin
      t_req[p] = 0; t_we[p] = 0; t_adr[p] = '0; t_dat[p] = '0;
    end
  endtask

  task automatic trig(int port, int snd, int rcv);
    t_req[port] = 1; t_we[port] = 1; t_adr[port] = 16'h3FFC;
    t_dat[port] = (32'(snd) << 16) | 32'(rcv);
  endtask

  task automatic clr(int port, int rcv, logic [31:0] mask);
    t_req[port] = 1; t_we[port] = 1; t_adr[port] = 16'(rcv * 4); t_dat[port] = mask;
  endtask

  task automatic rd(int port, logic [15:0] a);
    t_req[port] = 1; t_we[port] = 0; t_adr[port] = a; t_dat[port] = '0;
  endtask

  // update model from the staged commands, then run one cycle
  task automatic step();
    logic [N-1:0] s_m [N];
    logic [N-1:0] c_m [N];
    for (int r = 0; r < N; r++) begin s_m[r] = '0; c_m[r] = '0; end
    for (int p = 0; p < N; p++) begin
      if (t_req[p] && t_we[p]) begin
        if (t_adr[p] == 16'h3FFC) begin
          int s = int'(t_dat[p][19:16]);
          int r = int'(t_dat[p][3:0]);
          if (s < N && r < N) s_m[r][s] = 1'b1;
        end else if (t_adr[p][1:0] == 2'b00 && int'(t_adr[p]) < 4 * N) begin
          c_m[int'(t_adr[p]) / 4] |= t_dat[p][N-1:0];
        end
      end
    end
    @(negedge clk);
    for (int r = 0; r < N; r++) exp_map[r] = (exp_map[r] & ~c_m[r]) | s_m[r];
    idle_all();
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // read every bitmap through its own port and compare lines
  task automatic check_all(string req);
    for (int p = 0; p < N; p++) rd(p, 16'(p * 4));
    step();
    for (int p = 0; p < N; p++) begin
      chk(req, bus_rdata[p*32 +: 32], 32'(exp_map[p]), $sformatf("bitmap %0d", p));
      chk("R5", 32'(ici_irq[p]), 32'(|exp_map[p]), $sformatf("irq %0d", p));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog: actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    idle_all();
    for (int r = 0; r < N; r++) exp_map[r] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1: reset state
    for (int p = 0; p < N; p++) chk("R1", bus_rdata[p*32 +: 32], 32'h0, "rdata after reset");
    chk("R1", 32'(ici_irq), 32'h0, "irq after reset");
    check_all("R1");

    // R2 R3 R4 R5: every sender/receiver pair, set then clear
    for (int s = 0; s < N; s++) begin
      for (int r = 0; r < N; r++) begin
        trig(s, s, r);
        step();
        chk("R2", 32'(ici_irq), 32'(1 << r), "irq after trigger");
        check_all("R2");
        clr(r, r, 32'hFFFF_FFFF);
        step();
        chk("R4", 32'(ici_irq), 32'h0, "irq after clear");
        check_all("R4");
      end
    end

    // R6: all ports signal receiver 2 at once
    for (int p = 0; p < N; p++) trig(p, p, 2);
    step();
    check_all("R6");
    chk("R6", 32'(exp_map[2]), 32'hF, "model all senders");
    // R4: partial clear, then zero write leaves bits
    clr(0, 2, 32'h5);
    step();
    check_all("R4");
    clr(1, 2, 32'h0);
    step();
    check_all("R4");
    // R6: two ports name the same sender bit
    trig(0, 3, 0); trig(1, 3, 0);
    step();
    check_all("R6");

    // R7: set and clear of one bit in the same cycle
    trig(3, 1, 2); clr(2, 2, 32'h2 | 32'h8);
    step();
    check_all("R7");
    chk("R7", 32'(exp_map[2]), 32'h2, "set wins, other bit cleared");

    // R3: read in the same cycle as a trigger sees the old value
    begin
      logic [N-1:0] old_v = exp_map[1];
      rd(0, 16'h0004); trig(2, 2, 1);
      step();
      chk("R3", bus_rdata[31:0], 32'(old_v), "read during trigger");
      check_all("R3");
    end

    // R8: out-of-range sender or receiver
    trig(0, 5, 1); trig(1, 1, 7); trig(2, 15, 15);
    step();
    check_all("R8");

    // R9: unmapped writes and reads
    t_req[0] = 1; t_we[0] = 1; t_adr[0] = 16'h0010; t_dat[0] = 32'hFFFF_FFFF;
    t_req[1] = 1; t_we[1] = 1; t_adr[1] = 16'h3FF8; t_dat[1] = 32'h0001_0000;
    t_req[2] = 1; t_we[2] = 1; t_adr[2] = 16'h0006; t_dat[2] = 32'hFFFF_FFFF;
    step();
    check_all("R9");
    rd(0, 16'h3FFC); rd(1, 16'h0010); rd(2, 16'h0002); rd(3, 16'h8000);
    step();
    for (int p = 0; p < N; p++) chk("R9", bus_rdata[p*32 +: 32], 32'h0, "unmapped read");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule